// File: doc/BRIEF.md
# Host Firmware-Space Window Translator

This block sits between a host-facing firmware bus decoder and the management controller's system bus master. For every host firmware or memory cycle it decides whether the host address falls inside one programmable window. On a hit it produces the matching management-side address. Matching and substitution use only address bits 31:16, so windows are placed and sized in 64 KiB steps. The lower 16 address bits pass through unchanged.

Software programs three 32-bit registers through a simple write/read port. The control register holds two enable bits, and both must be set for any hit. The base register carries the management-side high address bits in its upper half and the host-side window high bits in its lower half. The mask register splits the same way. In its upper half, a 1 selects a base bit for the translated address. In its lower half, a 1 marks a host bit that is passed through and ignored by the match. A power-of-two window of S bytes is programmed with mask = (~(S-1)) | ((S>>16)-1).

The hit, miss and translated-address results are registered and appear one clock after the host strobe.

Top module: `fw_window_xlate`

## Requirements
- R1: After reset, the control, base and mask registers all read 0, `xl_hit` and `xl_miss` are low, and every lookup misses.
- R2: A lookup can hit only when control bit 8 (translation enable) and control bit 10 (firmware-cycle enable) are both 1. If either bit is 0, every lookup misses, whatever the other control bits hold.
- R3: When enabled, a host address hits if host[31:16] equals base[15:0] at every bit position where mask[15:0] is 0.
- R4: On a hit, translated bits 31:16 equal (base[31:16] & mask[31:16]) | (host[31:16] & mask[15:0]).
- R5: On a hit, translated bits 15:0 equal host bits 15:0.
- R6: Exactly one of `xl_hit` or `xl_miss` pulses high in the cycle after a cycle with `host_strobe` high, and both are low otherwise. On a miss, `xl_addr` is 0.
- R7: A register write takes effect at the next clock edge. A lookup strobed in the same cycle as a write uses the register values from before that write.
- R8: Registers sit at byte offsets 0x0 (control), 0x8 (base) and 0xC (mask). Writes to any other offset change nothing, and reads from any other offset return 0.
- R9: With base = {B>>16, H>>16} and the mask formula above, where S is a power of two of at least 64 KiB and B and H are multiples of S, host addresses in [H, H+S) hit and map to B + (host - H). All other host addresses miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset, used for both writes and reads |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| host_strobe | input | 1 | Host cycle valid |
| host_addr | input | 32 | Host firmware-space address |
| xl_hit | output | 1 | Registered hit pulse |
| xl_miss | output | 1 | Registered miss pulse |
| xl_addr | output | 32 | Translated address, valid with `xl_hit` |

## Verification
The assertions check on every cycle that hit and miss never occur together, and that exactly one of them follows each strobe and neither appears without one. They also check that a disabled window always misses, that a miss carries a zero address, and that the low half passes through unchanged. In addition, they check that register writes land on the next edge and that writes to unused offsets leave every register untouched.

Only the bench can show that the match and merge give the right answer for whole windows. It sweeps several window sizes and placements, and checks host addresses on both sides of each window edge against addresses it computes arithmetically. It also checks the same-cycle write/lookup ordering and the two-bit enable gating.

// File: rtl/fw_window_xlate.sv
module fw_window_xlate #(
  parameter int AW = 32,
  parameter int OFS_W = 4,
  parameter int EN_XL_BIT = 8,
  parameter int EN_FW_BIT = 10,
  parameter logic [OFS_W-1:0] CTRL_OFS = 4'h0,
  parameter logic [OFS_W-1:0] BASE_OFS = 4'h8,
  parameter logic [OFS_W-1:0] MASK_OFS = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [OFS_W-1:0] reg_addr,
  input  logic [AW-1:0]    reg_wdata,
  output logic [AW-1:0]    reg_rdata,
  input  logic             host_strobe,
  input  logic [AW-1:0]    host_addr,
  output logic             xl_hit,
  output logic             xl_miss,
  output logic [AW-1:0]    xl_addr
);
  localparam int HW = AW / 2;

  logic [AW-1:0] ctrl_q, base_q, mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == CTRL_OFS) ctrl_q <= reg_wdata;
      if (reg_addr == BASE_OFS) base_q <= reg_wdata;
      if (reg_addr == MASK_OFS) mask_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == CTRL_OFS) reg_rdata = ctrl_q;
    if (reg_addr == BASE_OFS) reg_rdata = base_q;
    if (reg_addr == MASK_OFS) reg_rdata = mask_q;
  end

  wire          win_en  = ctrl_q[EN_XL_BIT] & ctrl_q[EN_FW_BIT];
  wire [HW-1:0] host_hi = host_addr[AW-1:HW];
  wire [HW-1:0] cmp_hi  = (host_hi ^ base_q[HW-1:0]) & ~mask_q[HW-1:0];
  wire          hit_now = win_en && (cmp_hi == '0);
  wire [HW-1:0] xl_hi   = (base_q[AW-1:HW] & mask_q[AW-1:HW]) |
                          (host_hi & mask_q[HW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xl_hit  <= 1'b0;
      xl_miss <= 1'b0;
      xl_addr <= '0;
    end else begin
      xl_hit  <= host_strobe & hit_now;
      xl_miss <= host_strobe & ~hit_now;
      if (host_strobe)
        xl_addr <= hit_now ? {xl_hi, host_addr[HW-1:0]} : '0;
    end
  end

  p_one_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(xl_hit && xl_miss));
  p_strobe_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    host_strobe |=> (xl_hit || xl_miss));
  p_no_strobe_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !host_strobe |=> !(xl_hit || xl_miss));
  p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    xl_miss |-> (xl_addr == '0));
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_strobe && !(ctrl_q[EN_XL_BIT] && ctrl_q[EN_FW_BIT])) |=> xl_miss);
  p_low_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    host_strobe |=> (!xl_hit || xl_addr[HW-1:0] == $past(host_addr[HW-1:0])));
  p_base_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == BASE_OFS) |=> base_q == $past(reg_wdata));
  p_stray_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr != CTRL_OFS && reg_addr != BASE_OFS && reg_addr != MASK_OFS)
    |=> ($stable(ctrl_q) && $stable(base_q) && $stable(mask_q)));
endmodule

// File: tb/fw_window_xlate_tb_top.sv
module fw_window_xlate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        host_strobe = 1'b0;
  logic [31:0] host_addr = '0;
  logic        xl_hit, xl_miss;
  logic [31:0] xl_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_window_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_strobe(host_strobe),
    .host_addr(host_addr), .xl_hit(xl_hit), .xl_miss(xl_miss), .xl_addr(xl_addr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic lookup(input logic [31:0] a, output logic [31:0] res);
    @(negedge clk);
    host_strobe = 1'b1; host_addr = a;
    @(negedge clk);
    host_strobe = 1'b0;
    res = {xl_hit, xl_miss, 30'd0} ^ xl_addr;
  endtask

  function automatic logic [31:0] exp_res(input logic hit, input logic [31:0] a);
    return hit ? ({1'b1, 1'b0, 30'd0} ^ a) : {1'b0, 1'b1, 30'd0};
  endfunction

  initial begin
    logic [31:0] v, r, host, bmc;
    int units, hw, bu;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(4'h0, v); check("R1 ctrl", v, 0);
    rd(4'h8, v); check("R1 base", v, 0);
    rd(4'hC, v); check("R1 mask", v, 0);
    check("R1 flags", {30'd0, xl_hit, xl_miss}, 0);
    lookup(32'h0000_1234, r); check("R1 lookup", r, exp_res(0, 0));
    // R6: no pulse without strobe
    @(negedge clk); check("R6 idle", {30'd0, xl_hit, xl_miss}, 0);

    // R3/R4/R5 with an irregular mask
    wr(4'h8, 32'hABCD_0012);
    wr(4'hC, 32'hFF00_00F0);
    wr(4'h0, 32'h0000_0500);
    lookup(32'h0052_1234, r); check("R4 merge", r, exp_res(1, 32'hAB50_1234));
    lookup(32'h0012_FFFF, r); check("R5 low pass", r, exp_res(1, 32'hAB10_FFFF));
    lookup(32'h0053_1234, r); check("R3 mismatch", r, exp_res(0, 0));
    lookup(32'h1012_0000, r); check("R3 high mismatch", r, exp_res(0, 0));

    // R2: enable gating
    wr(4'h0, 32'h0000_0100);
    lookup(32'h0012_0000, r); check("R2 bit8 only", r, exp_res(0, 0));
    wr(4'h0, 32'h0000_0400);
    lookup(32'h0012_0000, r); check("R2 bit10 only", r, exp_res(0, 0));
    wr(4'h0, 32'hFFFF_FAFF);
    lookup(32'h0012_0000, r); check("R2 other bits", r, exp_res(0, 0));
    wr(4'h0, 32'h0000_0500);
    lookup(32'h0012_0000, r); check("R2 both", r, exp_res(1, 32'hAB10_0000));

    // R8: stray offset
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, v); check("R8 stray read", v, 0);
    rd(4'h0, v); check("R8 ctrl kept", v, 32'h0000_0500);
    rd(4'h8, v); check("R8 base kept", v, 32'hABCD_0012);
    rd(4'hC, v); check("R8 mask kept", v, 32'hFF00_00F0);

    // R7: same-cycle write and lookup use old values
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'h0; reg_wdata = 0;
    host_strobe = 1'b1; host_addr = 32'h0012_0042;
    @(negedge clk);
    reg_we = 1'b0; host_strobe = 1'b0;
    r = {xl_hit, xl_miss, 30'd0} ^ xl_addr;
    check("R7 old values", r, exp_res(1, 32'hAB10_0042));
    lookup(32'h0012_0042, r); check("R7 new values", r, exp_res(0, 0));

    // R9: window sweeps
    for (int k = 0; k < 4; k++) begin
      units = (k == 0) ? 1 : (k == 1) ? 2 : (k == 2) ? 16 : 64;
      hw = units * 3;
      bu = 32'h8000 + units * 5;
      wr(4'h8, {bu[15:0], hw[15:0]});
      wr(4'hC, ~((units << 16) - 1) | (units - 1));
      wr(4'h0, 32'h0000_0500);
      for (int hu = 0; hu < 1024; hu += (units > 2 ? 3 : 1)) begin
        host = (hu << 16) | ((hu * 37) & 16'hFFFF);
        bmc = ((bu + hu - hw) << 16) | (host & 32'hFFFF);
        lookup(host, r);
        check("R9 sweep", r, exp_res(hu >= hw && hu < hw + units, bmc));
      end
      lookup((hw + 16'h4000) << 16, r); check("R9 far alias", r, exp_res(0, 0));
      lookup((hw + units - 1) << 16 | 32'hFFFF, r);
      check("R9 top edge", r, exp_res(1, ((bu + units - 1) << 16) | 32'hFFFF));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule